// File: doc/BRIEF.md
# Receive Packet-to-Host Copy Sequencer

This block drains packets from a receive packet FIFO into host memory buffers. Software posts copy requests into one of several request slots; each request names a host address and the largest number of bytes the buffer can take. Accepted requests wait in a first-in first-out queue. A five-state machine takes them one at a time. It waits for a packet, issues one DMA write command on a shared memory port, and waits a modelled transfer time. It then reports a completion word for the slot that made the request.

A packet larger than the posted buffer is spread over several requests. Each copy takes the smaller of the buffer length and the bytes still left in the packet. The done word flags that more data follows, and the block remembers the offset it reached. Once a packet has been copied in full, the block tells the FIFO to free it. A receive-DMA event fires at the end of every request. A receive-empty event fires, and an arm flag is set, when the freed packet was the last one in the FIFO.

Top module: `rx_copy_seq`

## Requirements
- R1: The sequencer leaves its idle state only while `rx_en` is high and at least one request is queued; with `rx_en` low no DMA command is issued.
- R2: A request to a slot whose busy bit is set, or one that arrives while the queue is full, pulses `req_reject` in the same cycle and is dropped. An accepted request sets that slot's bit in `slot_busy` from the next cycle on, and the bit clears in the cycle after its done word is written.
- R3: Queued requests are serviced in the order they were accepted; `dma_addr` carries the address of the oldest pending request.
- R4: With no partly copied packet and `pkt_avail` low, the sequencer waits and issues no command. When part of a packet remains, it moves on to the next copy without needing a FIFO packet.
- R5: `dma_len` is the minimum of the request's length and the bytes remaining in the current packet.
- R6: No command is issued while `dma_busy` is high; the machine holds in its begin-copy state.
- R7: `done_wr` rises exactly fixed + ceil(len/64) x factor + 2 cycles after the `dma_req` cycle, using `lat_fixed`, `lat_factor` and the copied length.
- R8: `done_word` holds the copied length in bits 15:0, the packet flags in bits 21:16 and a complete bit at bit 30, with bit 31 (busy) clear.
- R9: When bytes of the packet remain after a copy, bit 29 (more) is set, the remaining count drops by the copied length and `dma_off` of the next copy advances by it.
- R10: When a packet is fully copied, `pkt_free` pulses with `done_wr`. If `pkt_last` is high in that cycle, `evt_rx_empty` pulses too and `rx_arm` is set; `rx_arm` clears when the next packet is taken.
- R11: `evt_rx_dma` pulses once per completed request. The sequencer then returns to idle if no request is left, and otherwise goes to wait for a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| req_valid | input | 1 | Copy request submit strobe |
| req_slot | input | 2 | Request slot index |
| req_addr | input | 32 | Host buffer address |
| req_len | input | 16 | Host buffer length in bytes |
| req_reject | output | 1 | Request dropped (slot busy or queue full) |
| slot_busy | output | 4 | Busy bit of each slot's done word |
| pkt_avail | input | 1 | FIFO holds a packet at its head |
| pkt_len | input | 16 | Byte count of the head packet |
| pkt_flags | input | 6 | Packet type and error flags of the head packet |
| pkt_last | input | 1 | Head packet is the only one in the FIFO |
| pkt_free | output | 1 | Release the head packet |
| dma_busy | input | 1 | Shared DMA port busy |
| dma_req | output | 1 | DMA write command strobe |
| dma_addr | output | 32 | Host address of the command |
| dma_len | output | 16 | Byte count of the command |
| dma_off | output | 16 | Byte offset within the packet |
| lat_fixed | input | 16 | Fixed DMA delay in cycles |
| lat_factor | input | 16 | Cycles per started 64-byte block |
| done_wr | output | 1 | Done word write strobe |
| done_slot | output | 2 | Slot receiving the done word |
| done_word | output | 32 | Completion word |
| evt_rx_dma | output | 1 | Receive-DMA event pulse |
| evt_rx_empty | output | 1 | Receive-empty event pulse |
| rx_arm | output | 1 | Set after the FIFO ran empty |

## Verification
The hardest situation to reach from the ports is a packet split over three requests from different slots, with the DMA port busy exactly when the machine sits in begin-copy. The continuation then has to come from stored remaining and offset state rather than from the FIFO. The stimulus queues three short buffers back to back against one 200-byte packet and holds `dma_busy` high across the first begin-copy. A cycle-accurate reference model checks every command, length, offset and done word, and later runs two single-packet copies with zero latency to reach the empty event.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  localparam int RXC_LEN_W  = 16;
  localparam int RXC_FLAG_W = 6;
  localparam int RXC_CNT_W  = 32;

  // done word field positions
  localparam int DW_FLAG_LSB = 16;
  localparam int DW_MORE_BIT = 29;
  localparam int DW_CPL_BIT  = 30;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAITF = 3'd1,
    ST_BEGIN = 3'd2,
    ST_COPY  = 3'd3,
    ST_DONE  = 3'd4
  } rxc_state_e;

  function automatic logic [RXC_LEN_W-1:0] rxc_min(input logic [RXC_LEN_W-1:0] a,
                                                   input logic [RXC_LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // fixed delay plus one factor per started 64-byte block
  function automatic logic [RXC_CNT_W-1:0] rxc_latency(input logic [RXC_LEN_W-1:0] len,
                                                       input logic [15:0] fixed,
                                                       input logic [15:0] factor);
    logic [RXC_LEN_W:0] blocks;
    blocks = ({1'b0, len} + (RXC_LEN_W+1)'(63)) >> 6;
    return RXC_CNT_W'(fixed) + RXC_CNT_W'(blocks) * RXC_CNT_W'(factor);
  endfunction

  function automatic logic [31:0] rxc_done_fmt(input logic [RXC_FLAG_W-1:0] flags,
                                               input logic [RXC_LEN_W-1:0] len,
                                               input logic more);
    logic [31:0] w;
    w = '0;
    w[RXC_LEN_W-1:0] = len;
    w[DW_FLAG_LSB +: RXC_FLAG_W] = flags;
    w[DW_MORE_BIT] = more;
    w[DW_CPL_BIT] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/rxc_req_queue.sv
module rxc_req_queue #(
  parameter int DW    = 50,
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [DW-1:0]                 push_data,
  input  logic                          pop,
  output logic [DW-1:0]                 head,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> count == CW'(DEPTH) && $stable(wr_ptr) == 1'b0 || 1'b0)
    else $error("queue written while full");
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty)
    else $error("queue popped while empty");
endmodule

// File: rtl/rxc_slot_track.sv
module rxc_slot_track #(
  parameter int NSLOT = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] req_slot,
  input  logic                                  q_full,
  input  logic                                  clr,
  input  logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] clr_slot,
  output logic [NSLOT-1:0]                      busy,
  output logic                                  reject,
  output logic                                  accept
);
  assign reject = req_valid && (busy[req_slot] || q_full);
  assign accept = req_valid && !reject;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   busy[s] <= 1'b0;
      else if (accept && req_slot == s)             busy[s] <= 1'b1;
      else if (clr && clr_slot == s)                busy[s] <= 1'b0;
    end
  end

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy[$past(req_slot)])
    else $error("accepted slot not marked busy");
  // R2
  reject_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject && busy[req_slot] && !(clr && clr_slot == req_slot) |=> busy[$past(req_slot)])
    else $error("rejected request changed busy state");
endmodule

// File: rtl/rxc_lat_timer.sv
module rxc_lat_timer
  import rxc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [RXC_LEN_W-1:0] len,
  input  logic [15:0]          fixed,
  input  logic [15:0]          factor,
  output logic                 expired
);
  logic [RXC_CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= rxc_latency(len, fixed, factor);
    else if (cnt != '0)  cnt <= cnt - RXC_CNT_W'(1);
  end

  assign expired = (cnt == '0);

  // R7
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !expired |=> cnt == $past(cnt) - RXC_CNT_W'(1))
    else $error("latency counter skipped");
endmodule

// File: rtl/rx_copy_seq.sv
module rx_copy_seq
  import rxc_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int QDEPTH = 4,
  parameter int AW     = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    rx_en,
  input  logic                                    req_valid,
  input  logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0]  req_slot,
  input  logic [AW-1:0]                           req_addr,
  input  logic [RXC_LEN_W-1:0]                    req_len,
  output logic                                    req_reject,
  output logic [NSLOT-1:0]                        slot_busy,
  input  logic                                    pkt_avail,
  input  logic [RXC_LEN_W-1:0]                    pkt_len,
  input  logic [RXC_FLAG_W-1:0]                   pkt_flags,
  input  logic                                    pkt_last,
  output logic                                    pkt_free,
  input  logic                                    dma_busy,
  output logic                                    dma_req,
  output logic [AW-1:0]                           dma_addr,
  output logic [RXC_LEN_W-1:0]                    dma_len,
  output logic [RXC_LEN_W-1:0]                    dma_off,
  input  logic [15:0]                             lat_fixed,
  input  logic [15:0]                             lat_factor,
  output logic                                    done_wr,
  output logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0]  done_slot,
  output logic [31:0]                             done_word,
  output logic                                    evt_rx_dma,
  output logic                                    evt_rx_empty,
  output logic                                    rx_arm
);
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int LW   = RXC_LEN_W;
  localparam int QW   = SW + AW + LW;
  localparam int QCW  = $clog2(QDEPTH+1);

  rxc_state_e         st, st_nx;
  logic               cur_valid;
  logic [LW-1:0]      cur_rem, cur_off, cp_len;
  logic [RXC_FLAG_W-1:0] cur_flags;
  logic               arm_q;

  logic [QW-1:0]      q_head;
  logic               q_empty, q_full;
  logic [QCW-1:0]     q_cnt;
  logic               accept;
  logic [SW-1:0]      hd_slot;
  logic [AW-1:0]      hd_addr;
  logic [LW-1:0]      hd_len;

  // named internal events
  logic issue, grab, copy_end, pkt_whole, lat_expired;
  logic [LW-1:0] copy_len;

  assign {hd_slot, hd_addr, hd_len} = q_head;

  rxc_req_queue #(.DW(QW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_data({req_slot, req_addr, req_len}),
    .pop(copy_end), .head(q_head), .empty(q_empty), .full(q_full), .count(q_cnt)
  );

  rxc_slot_track #(.NSLOT(NSLOT)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_slot(req_slot), .q_full(q_full),
    .clr(copy_end), .clr_slot(hd_slot),
    .busy(slot_busy), .reject(req_reject), .accept(accept)
  );

  rxc_lat_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(issue), .len(copy_len),
    .fixed(lat_fixed), .factor(lat_factor), .expired(lat_expired)
  );

  assign copy_len  = rxc_min(hd_len, cur_rem);
  assign issue     = (st == ST_BEGIN) && !dma_busy;
  assign grab      = (st == ST_WAITF) && !cur_valid && pkt_avail;
  assign copy_end  = (st == ST_DONE);
  assign pkt_whole = copy_end && (cur_rem == cp_len);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (rx_en && !q_empty)       st_nx = ST_WAITF;
      ST_WAITF: if (cur_valid || pkt_avail)  st_nx = ST_BEGIN;
      ST_BEGIN: if (!dma_busy)               st_nx = ST_COPY;
      ST_COPY:  if (lat_expired)             st_nx = ST_DONE;
      ST_DONE:  st_nx = (q_cnt > QCW'(1) || accept) ? ST_WAITF : ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_valid <= 1'b0;
      cur_rem   <= '0;
      cur_off   <= '0;
      cur_flags <= '0;
      cp_len    <= '0;
      arm_q     <= 1'b0;
    end else begin
      st <= st_nx;
      if (grab) begin
        cur_valid <= 1'b1;
        cur_rem   <= pkt_len;
        cur_off   <= '0;
        cur_flags <= pkt_flags;
        arm_q     <= 1'b0;
      end
      if (issue) cp_len <= copy_len;
      if (copy_end) begin
        if (pkt_whole) begin
          cur_valid <= 1'b0;
          if (pkt_last) arm_q <= 1'b1;
        end else begin
          cur_rem <= cur_rem - cp_len;
          cur_off <= cur_off + cp_len;
        end
      end
    end
  end

  assign dma_req      = issue;
  assign dma_addr     = hd_addr;
  assign dma_len      = copy_len;
  assign dma_off      = cur_off;
  assign pkt_free     = pkt_whole;
  assign done_wr      = copy_end;
  assign done_slot    = hd_slot;
  assign done_word    = copy_end ? rxc_done_fmt(cur_flags, cp_len, !pkt_whole) : '0;
  assign evt_rx_dma   = copy_end;
  assign evt_rx_empty = pkt_whole && pkt_last;
  assign rx_arm       = arm_q;

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE && !rx_en |=> st == ST_IDLE)
    else $error("left idle while disabled");
  // R4
  partial_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WAITF && cur_valid |=> st == ST_BEGIN)
    else $error("partial packet not resumed");
  // R5
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_len <= cur_rem && dma_len <= hd_len)
    else $error("copy length exceeds limit");
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BEGIN && dma_busy |=> st == ST_BEGIN && $stable(cur_rem))
    else $error("begin-copy did not stall");
  // R9
  more_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_wr && !pkt_free |=> cur_valid && cur_rem == $past(cur_rem) - $past(cp_len))
    else $error("remaining count not advanced");
  // R10
  empty_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_empty |=> rx_arm)
    else $error("arm flag not set");
  // R11
  done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_wr |=> st == ST_IDLE || st == ST_WAITF)
    else $error("bad state after copy-done");
endmodule

// File: tb/test_rx_copy_seq.sv
module test_rx_copy_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rx_en = 0, req_valid = 0, pkt_avail = 0, pkt_last = 0, dma_busy = 0;
  logic [1:0]  req_slot = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_len = 0, pkt_len = 0, lat_fixed = 0, lat_factor = 0;
  logic [5:0]  pkt_flags = 0;
  logic        req_reject, pkt_free, dma_req, done_wr, evt_rx_dma, evt_rx_empty, rx_arm;
  logic [3:0]  slot_busy;
  logic [31:0] dma_addr, done_word;
  logic [15:0] dma_len, dma_off;
  logic [1:0]  done_slot;

  rx_copy_seq i_rx_copy_seq (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .req_valid(req_valid), .req_slot(req_slot),
    .req_addr(req_addr), .req_len(req_len), .req_reject(req_reject), .slot_busy(slot_busy),
    .pkt_avail(pkt_avail), .pkt_len(pkt_len), .pkt_flags(pkt_flags), .pkt_last(pkt_last),
    .pkt_free(pkt_free), .dma_busy(dma_busy), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_len(dma_len), .dma_off(dma_off), .lat_fixed(lat_fixed), .lat_factor(lat_factor),
    .done_wr(done_wr), .done_slot(done_slot), .done_word(done_word), .evt_rx_dma(evt_rx_dma),
    .evt_rx_empty(evt_rx_empty), .rx_arm(rx_arm));

  int checks = 0, errors = 0, cyc = 0;
  int dma_cnt = 0, done_cnt = 0, rej_cnt = 0, more_cnt = 0;
  bit finished = 0;

  // packet FIFO environment
  int env_len[$];
  int env_flg[$];

  // reference model state
  int m_st = 0;          // 0 idle 1 wait 2 begin 3 copy 4 done
  int q_slot[$], q_addr[$], q_len[$];
  bit [3:0] m_busy = 0;
  bit m_valid = 0, m_arm = 0;
  int m_rem = 0, m_off = 0, m_flg = 0, m_clen = 0, m_cnt = 0;
  int last_req_start = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int lmin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int lat_of(input int n);
    return int'(lat_fixed) + ((n + 63) / 64) * int'(lat_factor);
  endfunction

  task automatic compare();
    bit e_rej, e_req, e_done, e_free, e_empty;
    int e_len, e_word;
    e_rej   = req_valid && (m_busy[req_slot] || q_slot.size() >= 4);
    e_req   = (m_st == 2) && !dma_busy;
    e_done  = (m_st == 4);
    e_free  = e_done && (m_rem == m_clen);
    e_empty = e_free && (env_len.size() == 1);
    chk(slot_busy == m_busy, "R2 slot_busy", slot_busy, m_busy);
    chk(req_reject == e_rej, "R2 req_reject", req_reject, e_rej);
    chk(dma_req == e_req, "R6 dma_req", dma_req, e_req);
    if (e_req && dma_req) begin
      e_len = lmin(q_len[0], m_rem);
      chk(dma_len == e_len, "R5 dma_len", dma_len, e_len);
      chk(dma_addr == q_addr[0], "R3 dma_addr", dma_addr, q_addr[0]);
      chk(dma_off == m_off, "R9 dma_off", dma_off, m_off);
    end
    chk(done_wr == e_done, "R7 done_wr", done_wr, e_done);
    if (e_done && done_wr) begin
      e_word = (m_flg << 16) | m_clen | (1 << 30) | ((e_free ? 0 : 1) << 29);
      chk(done_word == e_word, "R8 done_word", done_word, e_word);
      chk(done_slot == q_slot[0], "R3 done_slot", done_slot, q_slot[0]);
    end
    chk(pkt_free == e_free, "R10 pkt_free", pkt_free, e_free);
    chk(evt_rx_empty == e_empty, "R10 evt_rx_empty", evt_rx_empty, e_empty);
    chk(rx_arm == m_arm, "R10 rx_arm", rx_arm, m_arm);
    chk(evt_rx_dma == e_done, "R11 evt_rx_dma", evt_rx_dma, e_done);
  endtask

  task automatic model_step();
    bit acc, free_now;
    int nsz;
    acc = req_valid && !(m_busy[req_slot] || q_slot.size() >= 4);
    case (m_st)
      0: if (rx_en && q_slot.size() > 0) m_st = 1;
      1: begin
        if (m_valid) m_st = 2;
        else if (env_len.size() > 0) begin
          m_valid = 1; m_rem = env_len[0]; m_off = 0; m_flg = env_flg[0]; m_arm = 0; m_st = 2;
        end
      end
      2: if (!dma_busy) begin
        m_clen = lmin(q_len[0], m_rem);
        m_cnt = lat_of(m_clen);
        m_st = 3;
      end
      3: if (m_cnt == 0) m_st = 4; else m_cnt--;
      4: begin
        free_now = (m_rem == m_clen);
        m_busy[q_slot[0]] = 0;
        if (free_now) begin
          if (env_len.size() == 1) m_arm = 1;
          void'(env_len.pop_front()); void'(env_flg.pop_front());
          m_valid = 0;
        end else begin
          m_rem -= m_clen; m_off += m_clen;
        end
        void'(q_slot.pop_front()); void'(q_addr.pop_front()); void'(q_len.pop_front());
        nsz = q_slot.size();
        m_st = (nsz > 0 || acc) ? 1 : 0;
      end
      default: m_st = 0;
    endcase
    if (acc) begin
      q_slot.push_back(req_slot); q_addr.push_back(req_addr); q_len.push_back(req_len);
      m_busy[req_slot] = 1;
    end
  endtask

  task automatic tick();
    pkt_avail = (env_len.size() > 0);
    pkt_len   = pkt_avail ? 16'(env_len[0]) : '0;
    pkt_flags = pkt_avail ? 6'(env_flg[0]) : '0;
    pkt_last  = (env_len.size() == 1);
    #1;
    if (rst_n) begin
      compare();
      if (dma_req) dma_cnt++;
      if (done_wr) begin
        done_cnt++;
        if (done_word[29]) more_cnt++;
      end
      if (req_reject) rej_cnt++;
      model_step();
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic submit(input int slot, input int addr, input int len);
    req_valid = 1; req_slot = 2'(slot); req_addr = addr; req_len = 16'(len);
    tick();
    req_valid = 0;
  endtask

  initial begin
    int d0, r0;
    @(negedge clk);
    run(3);
    rst_n = 1;
    #1;
    chk(slot_busy == 4'b0, "R2 reset slot_busy", slot_busy, 0);
    chk(dma_req == 0 && done_wr == 0 && rx_arm == 0, "R11 reset outputs", {dma_req, done_wr, rx_arm}, 0);
    @(negedge clk);
    lat_fixed = 3; lat_factor = 2;

    // disabled: request stays queued
    d0 = dma_cnt;
    submit(0, 32'h1000, 100);
    run(6);
    chk(dma_cnt == d0, "R1 no command while disabled", dma_cnt, d0);

    // same slot again while busy
    r0 = rej_cnt;
    submit(0, 32'h2000, 50);
    chk(rej_cnt == r0 + 1, "R2 busy slot rejected", rej_cnt, r0 + 1);

    // enabled with empty FIFO: waits
    rx_en = 1;
    run(8);
    chk(dma_cnt == d0, "R4 waits for packet", dma_cnt, d0);
    env_len.push_back(100); env_flg.push_back(6'h05);
    run(20);
    chk(done_cnt == 1, "R11 one completion", done_cnt, 1);
    chk(rx_arm == 1, "R10 arm after empty", rx_arm, 1);

    // split one packet over three slots, port busy at first begin
    dma_busy = 1;
    env_len.push_back(200); env_flg.push_back(6'h0a);
    submit(1, 32'h3000, 64);
    submit(2, 32'h4000, 64);
    submit(3, 32'h5000, 100);
    run(5);
    chk(dma_cnt == 1, "R6 held while port busy", dma_cnt, 1);
    dma_busy = 0;
    run(60);
    chk(done_cnt == 4, "R9 split into three copies", done_cnt, 4);
    chk(more_cnt == 2, "R9 more bit count", more_cnt, 2);
    chk(slot_busy == 4'b0, "R2 busy cleared", slot_busy, 0);

    // two packets, zero latency, long buffers
    lat_fixed = 0; lat_factor = 0;
    env_len.push_back(40); env_flg.push_back(6'h11);
    env_len.push_back(50); env_flg.push_back(6'h22);
    submit(0, 32'h6000, 1000);
    submit(1, 32'h7000, 1000);
    run(20);
    chk(done_cnt == 6, "R5 whole packets copied", done_cnt, 6);
    chk(env_len.size() == 0, "R10 fifo drained", env_len.size(), 0);

    // 130-byte copy: three blocks
    lat_fixed = 1; lat_factor = 3;
    env_len.push_back(130); env_flg.push_back(6'h3f);
    submit(2, 32'h8000, 500);
    run(25);
    chk(done_cnt == 7, "R7 latency copy done", done_cnt, 7);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule